// File: doc/BRIEF.md
# Conversion and Calibration Ready Sequencer

This block paces the data-ready flag of an oversampling converter. A tick input marks each output-data-rate period. Once the filter-sync hold is released, or once a self-calibration is requested, the block counts whole periods. After a mode-dependent number of them it loads the newest filter result into its data register and drives an active-low ready flag. A completed read of the data register raises the flag again. After the first result, every further tick loads a fresh result and lowers the flag once more.

The block also holds the two-bit operating mode. A calibration request returns the mode to normal on its own when the calibration-plus-first-conversion window ends. Offset and gain coefficient writes are gated to normal mode. The first result that lands after an accepted coefficient write is marked as one the host should throw away.

Top module: `ready_seq`

## Requirements
- R1: After reset, drdy_n is 1, mode is 00, data_out is 0 and discard is 0. No count starts until sync falls from 1 to 0 or the mode is written, so ticks alone leave drdy_n at 1.
- R2: While fsync is 1, drdy_n stays at 1 and the period count is held at zero, whatever ticks arrive.
- R3: In any mode other than 01, counting starts in the cycle after the edge that sees fsync fall. drdy_n goes to 0 on the third tick counted, and data_out takes result_in at that same edge.
- R4: rd_done in a cycle without a tick sets drdy_n to 1 at the next edge.
- R5: Once a first result has been loaded, every tick loads result_in into data_out and drives drdy_n to 0. A tick takes precedence over rd_done in the same cycle.
- R6: Writing mode 01 (self-calibration) while fsync is 0 sets drdy_n to 1 and restarts the count. drdy_n goes to 0 on the ninth tick, and at that same edge mode reads 00.
- R7: A mode written while fsync is 1 is stored, but nothing starts. The count begins when fsync falls, using the stored mode's period count.
- R8: coef_ok equals coef_wr in the same cycle when mode is 00. An accepted write sets discard to 1 on the next result load, and the load after that clears it.
- R9: coef_wr while mode is 01 is rejected: coef_ok is 0, and the next result load gives discard 0.
- R10: Raising fsync during a count aborts it. drdy_n is 1 and the count is cleared, so after the next fall the full three ticks are needed again.
- R11: Mode codes 10 and 11 are stored as written and timed like normal conversion (three ticks). They are not cleared automatically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per output-data-rate period |
| fsync | input | 1 | Filter sync hold, 1 holds the sequence idle |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_in | input | 2 | Mode value to write (00 normal, 01 self-calibration) |
| coef_wr | input | 1 | Offset/gain coefficient write request |
| rd_done | input | 1 | Pulse when a data-register read has completed |
| result_in | input | W | Newest filter result |
| drdy_n | output | 1 | Active-low data-ready flag |
| mode | output | 2 | Current mode bits |
| coef_ok | output | 1 | Coefficient write accepted this cycle |
| data_out | output | W | Data register |
| discard | output | 1 | Current data-register result should be discarded |

## Verification
An off-by-one in the period counter shows at drdy_n as a fall exactly one tick early or late, so it appears at the first result after any sync release or calibration request. A lost abort or a stale count shows up after the very next fsync fall as a premature fall. A stuck mode register, or a pending-discard flag that is never cleared, shows on the first result after calibration or after a coefficient write: mode fails to read 00, or discard is wrong on that result or the one after it.

// File: rtl/ready_seq.sv
`timescale 1ns/1ps
module ready_seq #(
  parameter int W = 16,
  parameter int CONV_PERIODS = 3,
  parameter int CAL_PERIODS = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         fsync,
  input  logic         mode_wr,
  input  logic [1:0]   mode_in,
  input  logic         coef_wr,
  input  logic         rd_done,
  input  logic [W-1:0] result_in,
  output logic         drdy_n,
  output logic [1:0]   mode,
  output logic         coef_ok,
  output logic [W-1:0] data_out,
  output logic         discard
);
  localparam int CW = $clog2(CAL_PERIODS + 1);
  localparam logic [CW-1:0] CAL_LAST  = CW'(CAL_PERIODS - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_PERIODS - 1);
  localparam logic [1:0] M_CAL = 2'b01;

  logic [CW-1:0] cnt;
  logic running, streaming, fsync_q, disc_pend;

  wire start = ~fsync & ((fsync_q & ~fsync) | mode_wr);
  wire [CW-1:0] last = (mode == M_CAL) ? CAL_LAST : CONV_LAST;
  wire done = running & tick & (cnt == last);
  wire load = done | (streaming & tick);
  assign coef_ok = coef_wr & (mode == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; running <= 1'b0; streaming <= 1'b0; fsync_q <= 1'b0;
      disc_pend <= 1'b0; drdy_n <= 1'b1; mode <= 2'b00;
      data_out <= '0; discard <= 1'b0;
    end else begin
      fsync_q <= fsync;
      if (fsync) begin
        running <= 1'b0; streaming <= 1'b0; cnt <= '0; drdy_n <= 1'b1;
      end else if (start) begin
        running <= 1'b1; streaming <= 1'b0; cnt <= '0; drdy_n <= 1'b1;
      end else if (load) begin
        running <= 1'b0; streaming <= 1'b1; cnt <= '0; drdy_n <= 1'b0;
        data_out <= result_in;
        discard <= disc_pend;
        disc_pend <= 1'b0;
        if (done && mode == M_CAL) mode <= 2'b00;
      end else begin
        if (running && tick) cnt <= cnt + 1'b1;
        if (rd_done) drdy_n <= 1'b1;
      end
      if (mode_wr) mode <= mode_in;
      if (coef_ok) disc_pend <= 1'b1;
    end
  end

  a_r2_sync_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> drdy_n);
  a_r4_read_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !tick) |=> drdy_n);
  a_r5_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(tick));
  a_r5_data_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> !drdy_n);
  a_r6_mode_changes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(mode_wr) || $fell(drdy_n)));
  a_r8_discard_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discard) |-> !drdy_n);
endmodule

// File: tb/ready_seq_test.sv
`timescale 1ns/1ps
module ready_seq_test;
  logic clk = 0, rst_n = 0, tick = 0, fsync = 0, mode_wr = 0, coef_wr = 0, rd_done = 0;
  logic [1:0] mode_in = 0;
  logic [15:0] result_in = 0;
  logic drdy_n, coef_ok, discard;
  logic [1:0] mode;
  logic [15:0] data_out;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ready_seq uut (.clk(clk), .rst_n(rst_n), .tick(tick), .fsync(fsync), .mode_wr(mode_wr),
    .mode_in(mode_in), .coef_wr(coef_wr), .rd_done(rd_done), .result_in(result_in),
    .drdy_n(drdy_n), .mode(mode), .coef_ok(coef_ok), .data_out(data_out), .discard(discard));

  // {rd_done, tick, result_in, expected drdy_n, expected data_out}
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 1'b0, 16'h0000, 1'b1, 16'hA1A1},
    {1'b0, 1'b1, 16'hB2B2, 1'b0, 16'hB2B2},
    {1'b0, 1'b1, 16'hC3C3, 1'b0, 16'hC3C3},
    {1'b1, 1'b1, 16'hD4D4, 1'b0, 16'hD4D4},
    {1'b1, 1'b0, 16'h0000, 1'b1, 16'hD4D4},
    {1'b0, 1'b0, 16'h0000, 1'b1, 16'hD4D4},
    {1'b0, 1'b1, 16'hE5E5, 1'b0, 16'hE5E5},
    {1'b1, 1'b0, 16'h0000, 1'b1, 16'hE5E5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic r, input logic [15:0] res);
    @(negedge clk); tick = t; rd_done = r; result_in = res;
    @(posedge clk); #1; tick = 0; rd_done = 0;
  endtask

  task automatic setfs(input logic v);
    @(negedge clk); fsync = v;
    @(posedge clk); #1;
  endtask

  task automatic wrmode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_in = m;
    @(posedge clk); #1; mode_wr = 0;
  endtask

  task automatic coef(input logic exp_ok, input string req);
    @(negedge clk); coef_wr = 1; #1;
    check(req, coef_ok, exp_ok);
    @(posedge clk); #1; coef_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    check("R1 drdy_n", drdy_n, 1); check("R1 mode", mode, 0);
    check("R1 data", data_out, 0); check("R1 discard", discard, 0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 16'h1111);
    check("R1 no start on ticks", drdy_n, 1);

    setfs(1);
    for (int i = 0; i < 5; i++) cyc(1, 0, 16'h2222);
    check("R2 held high", drdy_n, 1);
    setfs(0);
    cyc(1, 0, 16'h0); cyc(1, 0, 16'h0);
    check("R3 high after two", drdy_n, 1);
    cyc(1, 0, 16'hA1A1);
    check("R3 low on third", drdy_n, 0); check("R3 data", data_out, 16'hA1A1);

    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][33], VEC[i][34], VEC[i][32:17]);
      check("R4/R5 drdy_n", drdy_n, VEC[i][16]);
      check("R5 data", data_out, VEC[i][15:0]);
    end

    setfs(1); check("R10 abort high", drdy_n, 1);
    setfs(0); cyc(1, 0, 0); cyc(1, 0, 0);
    setfs(1); setfs(0);
    cyc(1, 0, 0); cyc(1, 0, 0);
    check("R10 count cleared", drdy_n, 1);
    cyc(1, 0, 16'h3C3C); check("R10 low after full three", drdy_n, 0);

    wrmode(2'b01);
    check("R6 high at cal start", drdy_n, 1); check("R6 mode cal", mode, 1);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);
    coef(0, "R9 coef_ok in cal");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);
    check("R6 high after eight", drdy_n, 1);
    cyc(1, 0, 16'h5A5A);
    check("R6 low on ninth", drdy_n, 0); check("R6 mode cleared", mode, 0);
    check("R9 no discard", discard, 0);

    coef(1, "R8 coef_ok in normal");
    cyc(1, 0, 16'h6B6B); check("R8 discard set", discard, 1);
    cyc(1, 0, 16'h7C7C); check("R8 discard cleared", discard, 0);

    setfs(1); wrmode(2'b01);
    check("R7 mode stored", mode, 1);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0);
    check("R7 no start under sync", drdy_n, 1);
    setfs(0);
    for (int i = 0; i < 8; i++) cyc(1, 0, 0);
    check("R7 high after eight", drdy_n, 1);
    cyc(1, 0, 16'h8D8D);
    check("R7 low on ninth", drdy_n, 0); check("R7 mode cleared", mode, 0);

    wrmode(2'b10);
    check("R11 mode stored", mode, 2);
    cyc(1, 0, 0); cyc(1, 0, 0); check("R11 high after two", drdy_n, 1);
    cyc(1, 0, 16'h9E9E);
    check("R11 low on third", drdy_n, 0); check("R11 mode kept", mode, 2);

    @(negedge clk); rst_n = 0; @(posedge clk); #1;
    check("R1 reset drdy_n", drdy_n, 1); check("R1 reset mode", mode, 0);
    check("R1 reset data", data_out, 0);
    rst_n = 1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule